// File: doc/BRIEF.md
# Power Mode Controller with Complement-Confirmed Writes

This block holds the power mode of a storage device: reset, normal or deep power-down. Software cannot switch the mode with a single write. It first writes the new value to a control register. It then writes the bitwise complement of that value to a separate confirmation register. Any other order, a bad complement, or a write to some other register in between cancels the pending change.

The mode can be read back at any time through the control register. A pulse on the hardware reset pin returns the block to reset mode. While in deep power-down, a host read cycle also returns it to reset mode. Normal mode is reached only through a confirmed write pair. A power-down enable output follows the deep power-down mode so that the surrounding power logic can act on it.

All state is clocked. The synchronous active-high `rst` puts the block in its initial state. Register writes are one-cycle strobes with an address and a data byte.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: While `rst` is high, and in the cycle after it falls, the mode is reset (2'b00), `pd_en` is low and no change is pending.
- R2: A control write of byte V followed by a confirmation write of exactly ~V changes the mode to V[1:0] on the clock edge that takes the confirmation write. The mode encoding is reset 2'b00, normal 2'b01 and deep power-down 2'b10. The control write alone leaves the mode unchanged.
- R3: A confirmation write whose byte is not the exact complement of the pending byte leaves the mode unchanged and discards the pending byte.
- R4: A confirmation write with no pending byte, including one issued before its control write, has no effect on the mode.
- R5: A write to any address other than control (address 0) or confirmation (address 1), made between the two writes, discards the pending byte.
- R6: A control write whose low two bits are 2'b11 is ignored, even when it is correctly confirmed, and the mode is never 2'b11.
- R7: Idle cycles and read strobes between the control write and the confirmation write do not break the pair.
- R8: `pd_en` is high exactly when the mode is deep power-down.
- R9: A read strobe in deep power-down moves the mode to reset on that edge. A read strobe in any other mode has no effect.
- R10: `pin_rst` high forces reset mode and discards any pending byte. It wins over a confirmation write in the same cycle.
- R11: `rd_data` always shows the current mode in bits [1:0], with all higher bits zero.
- R12: A second control write replaces the pending byte. Only the complement of the latest byte confirms.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high block reset |
| wr_en | input | 1 | Register write strobe, one cycle per write |
| wr_addr | input | ADDR_W (2) | Write address: 0 control, 1 confirmation, others foreign registers |
| wr_data | input | DATA_W (8) | Write data byte |
| rd_stb | input | 1 | Host read cycle strobe |
| pin_rst | input | 1 | Hardware reset pin, active high, sampled on the clock |
| mode | output | 2 | Current mode |
| pd_en | output | 1 | Deep power-down enable |
| rd_data | output | DATA_W (8) | Control register read-back |

## Verification
The hardware reset pin and a confirmation write that completes a valid pair can fall in the same cycle. The bench arms a pending normal-mode value and then drives `pin_rst` together with the matching confirmation write. It expects reset mode afterwards. It also expects a later repeat of the confirmation to do nothing, because the pin has discarded the pending byte. A read strobe in deep power-down, together with a valid confirmation to deep power-down, is a second such collision. There the bench expects the confirmed write to win. Every data byte is swept through a confirmed pair, and the expected mode is taken from its low bits.

// File: rtl/pmc_pkg.sv
package pmc_pkg;

    typedef enum logic [1:0] {
        PM_RESET  = 2'b00,
        PM_NORMAL = 2'b01,
        PM_DEEP   = 2'b10
    } pm_mode_e;

    typedef enum logic [1:0] {
        WK_NONE,
        WK_CTRL,
        WK_CONF,
        WK_OTHER
    } wr_kind_e;

    typedef struct packed {
        logic     fire;
        pm_mode_e mode;
    } pm_commit_t;

    localparam int MODE_W = 2;

    function automatic logic mode_is_legal(input logic [MODE_W-1:0] m);
        return (m != 2'b11);
    endfunction

endpackage

// File: rtl/pmc_wr_decode.sv
module pmc_wr_decode
    import pmc_pkg::*;
#(
    parameter int ADDR_W    = 2,
    parameter int CTRL_ADDR = 0,
    parameter int CONF_ADDR = 1
) (
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    output wr_kind_e          kind
);
    localparam logic [ADDR_W-1:0] CTRL_A = ADDR_W'(CTRL_ADDR);
    localparam logic [ADDR_W-1:0] CONF_A = ADDR_W'(CONF_ADDR);

    always_comb begin
        if (!wr_en)                kind = WK_NONE;
        else if (wr_addr == CTRL_A) kind = WK_CTRL;
        else if (wr_addr == CONF_A) kind = WK_CONF;
        else                        kind = WK_OTHER;
    end
endmodule

// File: rtl/pmc_pending.sv
module pmc_pending
    import pmc_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              pin_rst,
    input  wr_kind_e          kind,
    input  logic [DATA_W-1:0] wr_data,
    output pm_commit_t        commit
);
    logic              pend_valid;
    logic [DATA_W-1:0] pend_val;

    always_ff @(posedge clk) begin
        if (rst || pin_rst) begin
            pend_valid <= 1'b0;
            pend_val   <= '0;
        end else begin
            case (kind)
                WK_CTRL: begin
                    pend_valid <= mode_is_legal(wr_data[MODE_W-1:0]);
                    pend_val   <= wr_data;
                end
                WK_CONF, WK_OTHER: pend_valid <= 1'b0;
                default: ;
            endcase
        end
    end

    always_comb begin
        commit.fire = (kind == WK_CONF) && pend_valid && (wr_data == ~pend_val);
        commit.mode = pm_mode_e'(pend_val[MODE_W-1:0]);
    end
endmodule

// File: rtl/pmc_mode_fsm.sv
module pmc_mode_fsm
    import pmc_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       pin_rst,
    input  logic       rd_stb,
    input  pm_commit_t commit,
    output pm_mode_e   mode_q
);
    always_ff @(posedge clk) begin
        if (rst || pin_rst)
            mode_q <= PM_RESET;
        else if (commit.fire)
            mode_q <= commit.mode;
        else if (rd_stb && mode_q == PM_DEEP)
            mode_q <= PM_RESET;
    end
endmodule

// File: rtl/pmc_readback.sv
module pmc_readback
    import pmc_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  pm_mode_e          mode_q,
    output logic [DATA_W-1:0] rd_data,
    output logic              pd_en
);
    localparam int PAD_W = DATA_W - MODE_W;

    generate
        if (PAD_W > 0) begin : g_pad
            assign rd_data = {{PAD_W{1'b0}}, mode_q};
        end else begin : g_nopad
            assign rd_data = mode_q;
        end
    endgenerate

    assign pd_en = (mode_q == PM_DEEP);
endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl
    import pmc_pkg::*;
#(
    parameter int ADDR_W    = 2,
    parameter int DATA_W    = 8,
    parameter int CTRL_ADDR = 0,
    parameter int CONF_ADDR = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_stb,
    input  logic              pin_rst,
    output logic [1:0]        mode,
    output logic              pd_en,
    output logic [DATA_W-1:0] rd_data
);
    wr_kind_e   kind;
    pm_commit_t commit;
    pm_mode_e   mode_q;

    pmc_wr_decode #(
        .ADDR_W(ADDR_W), .CTRL_ADDR(CTRL_ADDR), .CONF_ADDR(CONF_ADDR)
    ) u_dec (
        .wr_en(wr_en), .wr_addr(wr_addr), .kind(kind)
    );

    pmc_pending #(.DATA_W(DATA_W)) u_pend (
        .clk(clk), .rst(rst), .pin_rst(pin_rst),
        .kind(kind), .wr_data(wr_data), .commit(commit)
    );

    pmc_mode_fsm u_fsm (
        .clk(clk), .rst(rst), .pin_rst(pin_rst),
        .rd_stb(rd_stb), .commit(commit), .mode_q(mode_q)
    );

    pmc_readback #(.DATA_W(DATA_W)) u_rb (
        .mode_q(mode_q), .rd_data(rd_data), .pd_en(pd_en)
    );

    assign mode = mode_q;
endmodule

// File: rtl/pmc_checker.sv
module pmc_checker #(
    parameter int ADDR_W    = 2,
    parameter int DATA_W    = 8,
    parameter int CONF_ADDR = 1
) (
    input logic              clk,
    input logic              rst,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [DATA_W-1:0] wr_data,
    input logic              rd_stb,
    input logic              pin_rst,
    input logic [1:0]        mode,
    input logic              pd_en,
    input logic [DATA_W-1:0] rd_data
);
    logic rst_seen;
    logic conf_wr;
    assign conf_wr = wr_en && (wr_addr == ADDR_W'(CONF_ADDR));

    always_ff @(posedge clk) rst_seen <= rst;

    // R1: one edge after reset was sampled, the mode is reset and pd_en low
    always @(posedge clk) begin
        if (rst_seen === 1'b1)
            assert_reset_state_R1: assert (mode == 2'b00 && !pd_en);
    end

    assert_mode_change_cause_R2: assert property (@(posedge clk) disable iff (rst)
        (!pin_rst && !rd_stb && !conf_wr) |=> $stable(mode));

    assert_never_illegal_R6: assert property (@(posedge clk) disable iff (rst)
        mode != 2'b11);

    assert_pd_follows_mode_R8: assert property (@(posedge clk) disable iff (rst)
        pd_en == (mode == 2'b10));

    assert_read_wakes_R9: assert property (@(posedge clk) disable iff (rst)
        (rd_stb && mode == 2'b10 && !pin_rst && !conf_wr) |=> mode == 2'b00);

    assert_pin_wins_R10: assert property (@(posedge clk) disable iff (rst)
        pin_rst |=> (mode == 2'b00 && !pd_en));

    assert_readback_R11: assert property (@(posedge clk) disable iff (rst)
        rd_data == DATA_W'(mode));
endmodule

bind pwr_mode_ctrl pmc_checker #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CONF_ADDR(CONF_ADDR)
) u_chk (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_stb(rd_stb), .pin_rst(pin_rst),
    .mode(mode), .pd_en(pd_en), .rd_data(rd_data)
);

// File: tb/tb_pwr_mode_ctrl.sv
`timescale 1ns/1ps
module tb_pwr_mode_ctrl;
    localparam int ADDR_W = 2;
    localparam int DATA_W = 8;

    logic              clk = 1'b0;
    logic              rst;
    logic              wr_en;
    logic [ADDR_W-1:0] wr_addr;
    logic [DATA_W-1:0] wr_data;
    logic              rd_stb;
    logic              pin_rst;
    logic [1:0]        mode;
    logic              pd_en;
    logic [DATA_W-1:0] rd_data;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    pwr_mode_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_stb(rd_stb), .pin_rst(pin_rst),
        .mode(mode), .pd_en(pd_en), .rd_data(rd_data)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic chk_mode(input string tag, input logic [1:0] exp);
        chk(tag, int'(mode), int'(exp));
        chk({tag, "/R8"}, int'(pd_en), int'(exp == 2'b10));
        chk({tag, "/R11"}, int'(rd_data), int'(exp));
    endtask

    task automatic wr(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic pulse_rd();
        @(negedge clk); rd_stb = 1'b1;
        @(negedge clk); rd_stb = 1'b0;
    endtask

    task automatic pulse_pin();
        @(negedge clk); pin_rst = 1'b1;
        @(negedge clk); pin_rst = 1'b0;
    endtask

    task automatic pair(input logic [DATA_W-1:0] d);
        wr(2'd0, d);
        wr(2'd1, ~d);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [1:0] cur;
        rst = 1'b1; wr_en = 0; wr_addr = 0; wr_data = 0; rd_stb = 0; pin_rst = 0;
        idle(3);
        rst = 1'b0;
        @(negedge clk);
        chk_mode("R1 reset state", 2'b00);

        // R1/R4: confirmation with nothing pending
        wr(2'd1, 8'hFE);
        chk_mode("R4 lone confirm after reset", 2'b00);

        // R2/R6: sweep every byte through a confirmed pair
        cur = 2'b00;
        for (int d = 0; d < 256; d++) begin
            wr(2'd0, 8'(d));
            chk("R2 ctrl alone keeps mode", int'(mode), int'(cur));
            wr(2'd1, ~8'(d));
            if (d[1:0] != 2'b11) cur = 2'(d);
            chk_mode((d[1:0] == 2'b11) ? "R6 illegal ignored" : "R2 pair commits", cur);
        end

        // R3: wrong complement, then late correct one is discarded
        pair(8'h01);
        for (int k = 0; k < 8; k++) begin
            wr(2'd0, 8'h02);
            wr(2'd1, 8'hFD ^ 8'(1 << k));
            chk_mode("R3 bad complement", 2'b01);
            wr(2'd1, 8'hFD);
            chk_mode("R3 pending discarded", 2'b01);
        end

        // R4: wrong order
        wr(2'd1, 8'hFD);
        wr(2'd0, 8'h02);
        idle(2);
        chk_mode("R4 wrong order", 2'b01);
        wr(2'd1, 8'hFD);
        chk_mode("R4 late confirm still pairs", 2'b10);
        pair(8'h01);

        // R5: foreign register writes in between
        for (int a = 2; a < 4; a++) begin
            wr(2'd0, 8'h02);
            wr(2'(a), 8'h55);
            wr(2'd1, 8'hFD);
            chk_mode("R5 foreign write breaks pair", 2'b01);
        end

        // R7 and R9: idle and read strobe in between, read no effect in normal
        wr(2'd0, 8'h02);
        idle(5);
        pulse_rd();
        chk_mode("R9 read in normal no effect", 2'b01);
        wr(2'd1, 8'hFD);
        chk_mode("R7 pair survives gaps", 2'b10);

        // R9: read wakes deep power-down
        pulse_rd();
        chk_mode("R9 read wakes", 2'b00);

        // R9 collision: confirm to deep while reading in deep
        pair(8'h02);
        wr(2'd0, 8'h02);
        @(negedge clk);
        wr_en = 1; wr_addr = 2'd1; wr_data = 8'hFD; rd_stb = 1;
        @(negedge clk);
        wr_en = 0; rd_stb = 0;
        chk_mode("R9 confirm beats read wake", 2'b10);

        // R12: latest control write replaces pending
        wr(2'd0, 8'h01);
        wr(2'd0, 8'h02);
        wr(2'd1, 8'hFE);
        chk_mode("R12 old complement rejected", 2'b10);
        wr(2'd0, 8'h01);
        wr(2'd0, 8'h00);
        wr(2'd1, 8'hFF);
        chk_mode("R12 latest value commits", 2'b00);

        // R10: pin wakes deep power-down and clears pending
        pair(8'h02);
        pulse_pin();
        chk_mode("R10 pin wakes", 2'b00);
        wr(2'd0, 8'h01);
        pulse_pin();
        wr(2'd1, 8'hFE);
        chk_mode("R10 pin clears pending", 2'b00);

        // R10 collision: pin and valid confirm in the same cycle
        wr(2'd0, 8'h01);
        @(negedge clk);
        wr_en = 1; wr_addr = 2'd1; wr_data = 8'hFE; pin_rst = 1;
        @(negedge clk);
        wr_en = 0; pin_rst = 0;
        chk_mode("R10 pin beats confirm", 2'b00);
        wr(2'd1, 8'hFE);
        chk_mode("R10 repeat confirm ignored", 2'b00);

        // R1: block reset from normal clears pending
        pair(8'h01);
        wr(2'd0, 8'h02);
        rst = 1'b1; idle(2); rst = 1'b0;
        @(negedge clk);
        chk_mode("R1 reset from normal", 2'b00);
        wr(2'd1, 8'hFD);
        chk_mode("R1 no pending after reset", 2'b00);

        finish_run();
    end
endmodule